// File: doc/BRIEF.md
# Floating-Point Register Rename Map

This block is the rename stage in front of a floating-point unit. Thirty-two architectural register numbers are translated onto a pool of forty physical registers. Every incoming instruction carries an opcode, an optional destination and three source register numbers. The sources are looked up in a map table. When the instruction writes a destination, it is given a fresh physical register from the head of a circular free list, and the map entry is pointed at that new register.

The physical register that the destination named before the rename is not released straight away. It is placed at the tail of a pending-return queue. Each completion pulse takes the oldest entry of that queue and puts it at the tail of the free list. Incoming instructions that need a destination are held off when no free register is left, or when the return queue has no room.

The renamed instruction appears on the output registers one clock after it is accepted. Decode, execution and any recovery of the map after an exception are done by other blocks.

Top module: `fp_rename_map`

## Requirements
- R1: After reset, architectural register i maps to physical register i for i = 0..31, the free list holds physical registers 32..39 in ascending order from its head, the return queue is empty, `out_valid` is 0, and `in_stall` is 0 while `in_valid` is 0.
- R2: An accepted instruction (`in_valid`=1, `in_stall`=0) appears one clock later with `out_valid`=1. Its opcode and destination-enable are copied through unchanged. Each of the three source numbers is replaced by the physical register that the map holds for it when the instruction is accepted.
- R3: An accepted instruction with `in_tgt_en`=1 receives the physical register at the free-list head on `out_tgt_phys`, and that register is removed from the list. Registers are handed out in the order they entered the free list.
- R4: For an accepted instruction with `in_tgt_en`=1, `out_old_phys` shows the mapping its destination had before the rename. That old mapping is appended to the return queue, and later instructions see the new mapping. A source that names the same register as the destination reads the old mapping.
- R5: In a cycle with `cmpl_valid`=1 and a non-empty return queue, the oldest return-queue entry is moved to the free-list tail. When the return queue is empty at the start of the cycle, the pulse has no effect.
- R6: `in_stall` is 1 exactly when `in_valid`=1, `in_tgt_en`=1, and at the start of the cycle either the free list is empty or the return queue holds 8 entries. A stalled instruction produces no output and leaves the map and both queues unchanged.
- R7: An instruction with `in_tgt_en`=0 is never stalled, takes no register and changes no mapping. Its sources are still translated.
- R8: A rename and a completion in the same cycle both take effect. The register freed in that cycle goes behind any registers already in the free list. A rename that meets an empty free list stalls even if a completion arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming instruction present |
| in_op | input | OP_W | Opcode, passed through unchanged |
| in_tgt_en | input | 1 | Instruction writes a destination |
| in_tgt | input | 5 | Destination architectural register |
| in_src0 | input | 5 | Source 0 architectural register |
| in_src1 | input | 5 | Source 1 architectural register |
| in_src2 | input | 5 | Source 2 architectural register |
| cmpl_valid | input | 1 | Completion pulse, releases one pending register |
| in_stall | output | 1 | Incoming instruction is held off this cycle |
| out_valid | output | 1 | Renamed instruction present |
| out_op | output | OP_W | Opcode of renamed instruction |
| out_tgt_en | output | 1 | Renamed instruction writes a destination |
| out_tgt_phys | output | 6 | Newly allocated physical destination |
| out_old_phys | output | 6 | Previous physical mapping of the destination |
| out_src0_phys | output | 6 | Physical register for source 0 |
| out_src1_phys | output | 6 | Physical register for source 1 |
| out_src2_phys | output | 6 | Physical register for source 2 |

## Verification
A destination rename and a completion pulse can land in the same cycle: the first pops the free-list head and pushes the return queue, while the second pops the return queue and pushes the free-list tail. The bench provokes this on purpose. It does so while the free list is empty, while it holds exactly one register, and while the return queue is empty or full. It also lets random traffic overlap the two freely. A behavioural queue model in the bench predicts the stall and the allocated, old and source registers for every cycle, and these are compared at each clock.

// File: rtl/fpr_pkg.sv
// Shared constants for the floating-point rename stage.
// Assumes: physical pool strictly larger than architectural file.
package fpr_pkg;
    localparam int unsigned FPR_ARCH_REGS = 32;
    localparam int unsigned FPR_PHYS_REGS = 40;
    localparam int unsigned FPR_NUM_SRC   = 3;
    localparam int unsigned FPR_OP_W      = 6;
endpackage

// File: rtl/fpr_map_table.sv
// Architectural-to-physical map table with NRD combinational read
// ports and one synchronous write port.
// Assumes: a write is visible to reads from the next cycle on, so
// a read of the entry being written returns the old mapping.
module fpr_map_table #(
    parameter int unsigned N_ARCH = 32,
    parameter int unsigned PW     = 6,
    parameter int unsigned NRD    = 4,
    localparam int unsigned AW    = $clog2(N_ARCH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NRD-1:0][AW-1:0] rd_idx,
    output logic [NRD-1:0][PW-1:0] rd_phys,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_idx,
    input  logic [PW-1:0]          wr_phys
);
    logic [PW-1:0] map_q [N_ARCH];

    // Identity mapping on reset, single write per cycle otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(N_ARCH); i++) begin
                map_q[i] <= PW'(i);
            end
        end else if (wr_en) begin
            map_q[wr_idx] <= wr_phys;
        end
    end

    // Read ports, one per requested operand.
    for (genvar g = 0; g < int'(NRD); g++) begin : g_rd
        assign rd_phys[g] = map_q[rd_idx[g]];
    end

    // R4: a write never points an entry at its own previous value
    map_write_changes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> map_q[$past(wr_idx)] != $past(map_q[wr_idx]));
endmodule

// File: rtl/fpr_circ_queue.sv
// Circular FIFO of physical register numbers with head/tail pointers.
// Optionally comes out of reset full with INIT_BASE..INIT_BASE+DEPTH-1.
// Assumes: caller never pushes when full nor pops when empty;
// push and pop may occur together.
module fpr_circ_queue #(
    parameter int unsigned DEPTH     = 8,
    parameter int unsigned W         = 6,
    parameter bit          INIT_FULL = 1'b0,
    parameter int unsigned INIT_BASE = 0,
    localparam int unsigned PTRW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head_data,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]    mem_q [DEPTH];
    logic [PTRW-1:0] head_q, tail_q;
    logic [CW-1:0]   cnt_q;

    function automatic logic [PTRW-1:0] ptr_inc(input logic [PTRW-1:0] p);
        return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage: preload on reset if requested, write at tail on push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem_q[i] <= INIT_FULL ? W'(INIT_BASE + i) : '0;
            end
        end else if (push) begin
            mem_q[tail_q] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= INIT_FULL ? CW'(DEPTH) : '0;
        end else begin
            if (push) tail_q <= ptr_inc(tail_q);
            if (pop)  head_q <= ptr_inc(head_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_data = mem_q[head_q];
    assign count     = cnt_q;
    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == CW'(DEPTH));

    // R6
    q_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R5
    q_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R3
    q_fifo_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && empty) |=> head_data == $past(push_data));
endmodule

// File: rtl/fp_rename_map.sv
// Rename stage of a floating-point unit. Sources are translated through
// the map table; a writing instruction takes the free-list head as its
// new destination and parks the displaced mapping in a pending-return
// queue, which drains one entry into the free list per completion.
// Assumes: completions arrive in the order renames happened; the map
// is not restored after exceptions here.
module fp_rename_map
    import fpr_pkg::*;
#(
    parameter int unsigned N_ARCH = FPR_ARCH_REGS,
    parameter int unsigned N_PHYS = FPR_PHYS_REGS,
    parameter int unsigned OP_W   = FPR_OP_W,
    localparam int unsigned AW    = $clog2(N_ARCH),
    localparam int unsigned PW    = $clog2(N_PHYS),
    localparam int unsigned SPARE = N_PHYS - N_ARCH,
    localparam int unsigned CW    = $clog2(SPARE + 1),
    localparam int unsigned NRD   = FPR_NUM_SRC + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [OP_W-1:0] in_op,
    input  logic            in_tgt_en,
    input  logic [AW-1:0]   in_tgt,
    input  logic [AW-1:0]   in_src0,
    input  logic [AW-1:0]   in_src1,
    input  logic [AW-1:0]   in_src2,
    input  logic            cmpl_valid,
    output logic            in_stall,
    output logic            out_valid,
    output logic [OP_W-1:0] out_op,
    output logic            out_tgt_en,
    output logic [PW-1:0]   out_tgt_phys,
    output logic [PW-1:0]   out_old_phys,
    output logic [PW-1:0]   out_src0_phys,
    output logic [PW-1:0]   out_src1_phys,
    output logic [PW-1:0]   out_src2_phys
);
    logic [NRD-1:0][AW-1:0] rd_idx;
    logic [NRD-1:0][PW-1:0] rd_phys;
    logic [PW-1:0]          fl_head, rq_head;
    logic [CW-1:0]          fl_cnt, rq_cnt;
    logic                   fl_empty, fl_full, rq_empty, rq_full;
    logic                   accept, alloc, release_one;

    // Lookup order: three sources, then destination for its old mapping.
    assign rd_idx = {in_tgt, in_src2, in_src1, in_src0};

    // Hold-off and event decode.
    always_comb begin
        in_stall    = in_valid && in_tgt_en && (fl_empty || rq_full);
        accept      = in_valid && !in_stall;
        alloc       = accept && in_tgt_en;
        release_one = cmpl_valid && !rq_empty;
    end

    fpr_map_table #(.N_ARCH(N_ARCH), .PW(PW), .NRD(NRD)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_idx),
        .rd_phys (rd_phys),
        .wr_en   (alloc),
        .wr_idx  (in_tgt),
        .wr_phys (fl_head)
    );

    fpr_circ_queue #(.DEPTH(SPARE), .W(PW), .INIT_FULL(1'b1),
                     .INIT_BASE(N_ARCH)) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (release_one),
        .push_data (rq_head),
        .pop       (alloc),
        .head_data (fl_head),
        .count     (fl_cnt),
        .empty     (fl_empty),
        .full      (fl_full)
    );

    fpr_circ_queue #(.DEPTH(SPARE), .W(PW), .INIT_FULL(1'b0),
                     .INIT_BASE(0)) u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (alloc),
        .push_data (rd_phys[NRD-1]),
        .pop       (release_one),
        .head_data (rq_head),
        .count     (rq_cnt),
        .empty     (rq_empty),
        .full      (rq_full)
    );

    // Output register stage for the renamed instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_op        <= '0;
            out_tgt_en    <= 1'b0;
            out_tgt_phys  <= '0;
            out_old_phys  <= '0;
            out_src0_phys <= '0;
            out_src1_phys <= '0;
            out_src2_phys <= '0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_op        <= in_op;
                out_tgt_en    <= in_tgt_en;
                out_tgt_phys  <= in_tgt_en ? fl_head : '0;
                out_old_phys  <= in_tgt_en ? rd_phys[NRD-1] : '0;
                out_src0_phys <= rd_phys[0];
                out_src1_phys <= rd_phys[1];
                out_src2_phys <= rd_phys[2];
            end
        end
    end

    // R5
    spare_conserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(fl_cnt) + 32'(rq_cnt)) == SPARE);
    // R6
    stall_blocks_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_stall |=> !out_valid);
    // R4
    new_differs_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tgt_en) |-> out_tgt_phys != out_old_phys);
    // R7
    no_tgt_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_tgt_en && !cmpl_valid) |=> $stable(fl_cnt));
    // R8
    empty_fl_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_tgt_en && fl_empty && cmpl_valid) |-> in_stall);
endmodule

// File: tb/sim_fp_rename_map.sv
module sim_fp_rename_map;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_tgt_en, cmpl_valid;
    logic [5:0] in_op;
    logic [4:0] in_tgt, in_src0, in_src1, in_src2;
    logic       in_stall, out_valid, out_tgt_en;
    logic [5:0] out_op, out_tgt_phys, out_old_phys;
    logic [5:0] out_src0_phys, out_src1_phys, out_src2_phys;

    always #2.5ns clk = ~clk;

    fp_rename_map u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_tgt_en(in_tgt_en), .in_tgt(in_tgt), .in_src0(in_src0),
        .in_src1(in_src1), .in_src2(in_src2), .cmpl_valid(cmpl_valid),
        .in_stall(in_stall), .out_valid(out_valid), .out_op(out_op),
        .out_tgt_en(out_tgt_en), .out_tgt_phys(out_tgt_phys),
        .out_old_phys(out_old_phys), .out_src0_phys(out_src0_phys),
        .out_src1_phys(out_src1_phys), .out_src2_phys(out_src2_phys)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model
    int map_m [32];
    int fl_m [$];
    int rq_m [$];
    bit e_valid, e_te;
    int e_op, e_tgt, e_old, e_s0, e_s1, e_s2;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input bit v, input int op, input bit te, input int t,
                       input int s0, input int s1, input int s2, input bit cm);
        bit st;
        int rq0;
        @(negedge clk);
        // compare previous cycle's prediction
        chk(out_valid == e_valid, "R2 out_valid", int'(out_valid), int'(e_valid));
        if (e_valid) begin
            chk(int'(out_op) == e_op, "R2 opcode", int'(out_op), e_op);
            chk(out_tgt_en == e_te, "R7 tgt_en", int'(out_tgt_en), int'(e_te));
            chk(int'(out_src0_phys) == e_s0, "R2 R4 src0", int'(out_src0_phys), e_s0);
            chk(int'(out_src1_phys) == e_s1, "R2 R4 src1", int'(out_src1_phys), e_s1);
            chk(int'(out_src2_phys) == e_s2, "R2 R4 src2", int'(out_src2_phys), e_s2);
            if (e_te) begin
                chk(int'(out_tgt_phys) == e_tgt, "R3 R5 R8 new tgt", int'(out_tgt_phys), e_tgt);
                chk(int'(out_old_phys) == e_old, "R4 old tgt", int'(out_old_phys), e_old);
            end
        end
        in_valid = v; in_op = 6'(op); in_tgt_en = te; in_tgt = 5'(t);
        in_src0 = 5'(s0); in_src1 = 5'(s1); in_src2 = 5'(s2); cmpl_valid = cm;
        #1ns;
        st = v && te && (fl_m.size() == 0 || rq_m.size() == 8);
        chk(in_stall == st, te ? "R6 R8 stall" : "R7 no stall", int'(in_stall), int'(st));
        rq0 = rq_m.size();
        e_valid = v && !st;
        if (e_valid) begin
            e_op = op; e_te = te;
            e_s0 = map_m[s0]; e_s1 = map_m[s1]; e_s2 = map_m[s2];
            if (te) begin
                e_old = map_m[t];
                e_tgt = fl_m.pop_front();
                rq_m.push_back(e_old);
                map_m[t] = e_tgt;
            end
        end
        if (cm && rq0 > 0) fl_m.push_back(rq_m.pop_front());
    endtask

    task automatic idle(input bit cm);
        cyc(1'b0, 0, 1'b0, 0, 0, 0, 0, cm);
    endtask

    initial begin
        #1000us;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 0; in_op = 0; in_tgt_en = 0; in_tgt = 0;
        in_src0 = 0; in_src1 = 0; in_src2 = 0; cmpl_valid = 0;
        for (int i = 0; i < 32; i++) map_m[i] = i;
        for (int i = 32; i < 40; i++) fl_m.push_back(i);
        e_valid = 0; e_te = 0; e_op = 0; e_tgt = 0; e_old = 0;
        e_s0 = 0; e_s1 = 0; e_s2 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1ns;
        // R1: reset state at the ports
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_stall == 1'b0, "R1 stall after reset", int'(in_stall), 0);
        // R1 map identity seen through sources, R4 src==tgt reads old
        cyc(1, 3, 1, 5, 5, 3, 31, 0);
        cyc(1, 4, 1, 5, 5, 5, 0, 0);
        cyc(1, 7, 0, 9, 5, 9, 12, 0);          // R7 no target
        for (int r = 1; r <= 6; r++) cyc(1, r, 1, r, r, 0, 5, 0);
        // free list now empty: R6 stall, R8 stall despite completion
        cyc(1, 1, 1, 7, 7, 7, 7, 0);
        cyc(1, 2, 1, 7, 7, 7, 7, 1);
        cyc(1, 3, 0, 7, 7, 7, 7, 0);           // R7 never stalls
        cyc(1, 4, 1, 8, 8, 5, 5, 1);           // R8 take one, free one
        cyc(1, 5, 1, 8, 8, 5, 5, 0);
        for (int k = 0; k < 9; k++) idle(1);   // R5 incl. pulse on empty queue
        idle(1);
        cyc(1, 6, 1, 10, 10, 10, 10, 1);       // R5 R8 with empty return queue
        idle(0);
        // random traffic
        for (int k = 0; k < 4000; k++) begin
            int t;
            t = $urandom % 32;
            cyc(($urandom % 4) != 0, $urandom % 64, ($urandom % 5) != 0, t,
                ($urandom % 3 == 0) ? t : $urandom % 32, $urandom % 32,
                $urandom % 32, ($urandom % 100) < ((k / 500) % 2 ? 60 : 25));
        end
        idle(0);
        idle(0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule